// File: doc/BRIEF.md
# Operand Forwarding Select and Load-Use Interlock

This block is the forwarding controller for a fully bypassed five-stage integer pipeline. The decode stage presents its two source register numbers with their read enables, and the class and destination of the instruction it holds. The block keeps a small record of the class and destination of the instructions now in the execute, memory and writeback stages. From that record it chooses, for each operand, where the operand value comes from: the register file read, the execute-stage ALU result, the execute-stage link address, the memory-stage stored result, the data memory read value, or the writeback-stage result.

An instruction produces its result in a stage that depends on its class. ALU and ALU-immediate results exist at the end of execute. Link addresses exist as soon as the instruction reaches execute. Load data exists only after the memory read. Every case can be forwarded except one: a load in execute whose destination a decode operand reads. For that case the block raises `stall`. The surrounding pipeline then holds fetch and decode, and the block puts a bubble, not the held instruction, into its execute record. On the next cycle the load sits in memory and its read data is forwarded.

The datapath muxes, the register file, the ALU and the data memory are outside the block.

Top module: `fwd_bypass_ctrl`

## Requirements
- R1: After reset the execute, memory and writeback records are empty, so every operand selects the register file (code 0) and `stall` is low.
- R2: An operand whose register matches the destination of an ALU (class 1) or ALU-immediate (class 2) instruction in execute selects the execute ALU result (code 1).
- R3: An operand that matches the destination of a link-writing jump (class 7) in execute selects the execute link address (code 2) and does not stall.
- R4: An enabled operand that matches the destination of a load (class 3) in execute raises `stall`. That operand keeps code 0. One cycle later the load is in memory and the operand selects the data memory read value (code 4).
- R5: An operand that matches a non-load writer (class 1, 2 or 7) in the memory stage selects the stored memory-stage result (code 3).
- R6: An operand that matches any writer in the writeback stage selects the writeback result (code 5).
- R7: When several stages match, the youngest producer is used: execute before memory before writeback.
- R8: A destination of register 0 is never forwarded and never causes a stall.
- R9: An operand whose read enable is low selects code 0 and never contributes to `stall`.
- R10: Stores (class 4), branches (class 5), plain jumps (class 6) and empty slots (class 0) never act as producers, whatever destination field they carry.
- R11: In a stall cycle a bubble enters the execute record instead of the decode instruction. The held instruction enters execute exactly once, on the first cycle without a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_cls | input | 3 | Class of the decode-stage instruction |
| dec_dst | input | 5 | Destination register the decode instruction writes |
| dec_rs | input | 5 | First source register (A operand) |
| dec_rs_en | input | 1 | First source is read |
| dec_rt | input | 5 | Second source register (B operand) |
| dec_rt_en | input | 1 | Second source is read |
| sel_a | output | 3 | A operand source code |
| sel_b | output | 3 | B operand source code |
| stall | output | 1 | Load-use interlock: hold fetch and decode |

## Verification
The bench puts a load in front of a dependent instruction and holds that instruction through the stall. It checks that the retry picks up the memory read value and that the stalled cycle left a bubble. A design that let the held instruction into execute during the stall would show it as its own producer on the retry. The bench stacks the same destination in two and three stages to catch a reversed priority, which would hand over stale data. It also writes register zero, clears read enables, and sends non-writing classes with a live destination field. A design that got any of these wrong would forward garbage or stall for no reason.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int CLS_W = 3;
    localparam int SEL_W = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_NOP    = 3'd0,
        CLS_ALU    = 3'd1,
        CLS_ALUI   = 3'd2,
        CLS_LOAD   = 3'd3,
        CLS_STORE  = 3'd4,
        CLS_BRANCH = 3'd5,
        CLS_JUMP   = 3'd6,
        CLS_LINK   = 3'd7
    } instr_cls_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_REGFILE    = 3'd0,
        SEL_EX_ALU     = 3'd1,
        SEL_EX_LINK    = 3'd2,
        SEL_MEM_RESULT = 3'd3,
        SEL_MEM_LOAD   = 3'd4,
        SEL_WB_RESULT  = 3'd5
    } opnd_sel_e;

    // Classes that write a general register.
    function automatic logic writes_reg(instr_cls_e c);
        return (c == CLS_ALU) || (c == CLS_ALUI) || (c == CLS_LOAD) || (c == CLS_LINK);
    endfunction

endpackage

// File: rtl/fwd_stage_track.sv
module fwd_stage_track
    import fwd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  instr_cls_e      dec_cls,
    input  logic [AW-1:0]   dec_dst,
    input  logic            bubble,
    output instr_cls_e      ex_cls,
    output logic [AW-1:0]   ex_dst,
    output instr_cls_e      mem_cls,
    output logic [AW-1:0]   mem_dst,
    output instr_cls_e      wb_cls,
    output logic [AW-1:0]   wb_dst
);

    typedef struct packed {
        instr_cls_e    cls;
        logic [AW-1:0] dst;
    } slot_t;

    typedef struct packed {
        slot_t ex;
        slot_t mem;
        slot_t wb;
    } track_t;

    track_t trk_d, trk_q;

    always_comb begin
        trk_d     = trk_q;
        trk_d.wb  = trk_q.mem;
        trk_d.mem = trk_q.ex;
        if (bubble) begin
            trk_d.ex.cls = CLS_NOP;
            trk_d.ex.dst = '0;
        end else begin
            trk_d.ex.cls = dec_cls;
            trk_d.ex.dst = dec_dst;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q.ex.cls  <= CLS_NOP;
            trk_q.ex.dst  <= '0;
            trk_q.mem.cls <= CLS_NOP;
            trk_q.mem.dst <= '0;
            trk_q.wb.cls  <= CLS_NOP;
            trk_q.wb.dst  <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign ex_cls  = trk_q.ex.cls;
    assign ex_dst  = trk_q.ex.dst;
    assign mem_cls = trk_q.mem.cls;
    assign mem_dst = trk_q.mem.dst;
    assign wb_cls  = trk_q.wb.cls;
    assign wb_dst  = trk_q.wb.dst;

endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
    import fwd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic          rd_en,
    input  instr_cls_e    ex_cls,
    input  logic [AW-1:0] ex_dst,
    input  instr_cls_e    mem_cls,
    input  logic [AW-1:0] mem_dst,
    input  instr_cls_e    wb_cls,
    input  logic [AW-1:0] wb_dst,
    output opnd_sel_e     sel,
    output logic          hazard
);

    logic hit_ex, hit_mem, hit_wb;

    always_comb begin
        hit_ex  = rd_en && (ex_dst  != '0) && (ex_dst  == src) && writes_reg(ex_cls);
        hit_mem = rd_en && (mem_dst != '0) && (mem_dst == src) && writes_reg(mem_cls);
        hit_wb  = rd_en && (wb_dst  != '0) && (wb_dst  == src) && writes_reg(wb_cls);

        sel    = SEL_REGFILE;
        hazard = 1'b0;
        if (hit_ex) begin
            // Youngest producer decides; a load here cannot be covered.
            case (ex_cls)
                CLS_ALU, CLS_ALUI: sel    = SEL_EX_ALU;
                CLS_LINK:          sel    = SEL_EX_LINK;
                CLS_LOAD:          hazard = 1'b1;
                default:           sel    = SEL_REGFILE;
            endcase
        end else if (hit_mem) begin
            sel = (mem_cls == CLS_LOAD) ? SEL_MEM_LOAD : SEL_MEM_RESULT;
        end else if (hit_wb) begin
            sel = SEL_WB_RESULT;
        end
    end

endmodule

// File: rtl/fwd_bypass_ctrl.sv
module fwd_bypass_ctrl
    import fwd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    dec_cls,
    input  logic [AW-1:0] dec_dst,
    input  logic [AW-1:0] dec_rs,
    input  logic          dec_rs_en,
    input  logic [AW-1:0] dec_rt,
    input  logic          dec_rt_en,
    output logic [2:0]    sel_a,
    output logic [2:0]    sel_b,
    output logic          stall
);

    localparam int NUM_OPND = 2;

    instr_cls_e    ex_cls, mem_cls, wb_cls;
    logic [AW-1:0] ex_dst, mem_dst, wb_dst;

    logic [AW-1:0] opnd_src [NUM_OPND];
    logic          opnd_en  [NUM_OPND];
    opnd_sel_e     opnd_sel [NUM_OPND];
    logic [NUM_OPND-1:0] opnd_hz;

    assign opnd_src[0] = dec_rs;
    assign opnd_en[0]  = dec_rs_en;
    assign opnd_src[1] = dec_rt;
    assign opnd_en[1]  = dec_rt_en;

    fwd_stage_track #(.AW(AW)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .dec_cls (instr_cls_e'(dec_cls)),
        .dec_dst (dec_dst),
        .bubble  (stall),
        .ex_cls  (ex_cls),
        .ex_dst  (ex_dst),
        .mem_cls (mem_cls),
        .mem_dst (mem_dst),
        .wb_cls  (wb_cls),
        .wb_dst  (wb_dst)
    );

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        fwd_operand_sel #(.AW(AW)) u_sel (
            .src     (opnd_src[g]),
            .rd_en   (opnd_en[g]),
            .ex_cls  (ex_cls),
            .ex_dst  (ex_dst),
            .mem_cls (mem_cls),
            .mem_dst (mem_dst),
            .wb_cls  (wb_cls),
            .wb_dst  (wb_dst),
            .sel     (opnd_sel[g]),
            .hazard  (opnd_hz[g])
        );
    end

    assign sel_a = opnd_sel[0];
    assign sel_b = opnd_sel[1];
    assign stall = |opnd_hz;

endmodule

// File: rtl/fwd_bypass_ctrl_chk.sv
module fwd_bypass_ctrl_chk
    import fwd_pkg::*;
#(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    dec_cls,
    input logic [AW-1:0] dec_dst,
    input logic [AW-1:0] dec_rs,
    input logic          dec_rs_en,
    input logic [AW-1:0] dec_rt,
    input logic          dec_rt_en,
    input logic [2:0]    sel_a,
    input logic [2:0]    sel_b,
    input logic          stall
);

    // R11: the bubble means a stall never lasts two cycles in a row
    a_r11_single_stall: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    // R4: a stall is caused only by a load accepted on the previous cycle
    a_r4_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> ($past(dec_cls) == 3'(CLS_LOAD)) && !$past(stall));

    // R2: an execute ALU forward comes from the instruction accepted last cycle
    a_r2_ex_alu_origin: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a == 3'(SEL_EX_ALU)) |->
            !$past(stall) && ($past(dec_dst) == dec_rs) &&
            (($past(dec_cls) == 3'(CLS_ALU)) || ($past(dec_cls) == 3'(CLS_ALUI))));

    // R3: a link forward comes from a link jump accepted last cycle, never with a stall
    a_r3_link_origin: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_b == 3'(SEL_EX_LINK)) |->
            !stall && ($past(dec_cls) == 3'(CLS_LINK)) && ($past(dec_dst) == dec_rt));

    // R8: register zero is read from the register file
    a_r8_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_rs == '0) |-> (sel_a == 3'(SEL_REGFILE)));

    // R9: a disabled operand selects the register file
    a_r9_rt_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_rt_en |-> (sel_b == 3'(SEL_REGFILE)));

    // R4: with a stall no operand takes an execute-stage value
    a_r4_stall_no_ex: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (sel_a != 3'(SEL_EX_ALU)) && (sel_a != 3'(SEL_EX_LINK)) &&
                  (sel_b != 3'(SEL_EX_ALU)) && (sel_b != 3'(SEL_EX_LINK)));

    // R4: a stall needs at least one enabled operand
    a_r4_stall_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (dec_rs_en || dec_rt_en));

endmodule

bind fwd_bypass_ctrl fwd_bypass_ctrl_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec_cls   (dec_cls),
    .dec_dst   (dec_dst),
    .dec_rs    (dec_rs),
    .dec_rs_en (dec_rs_en),
    .dec_rt    (dec_rt),
    .dec_rt_en (dec_rt_en),
    .sel_a     (sel_a),
    .sel_b     (sel_b),
    .stall     (stall)
);

// File: tb/sim_fwd_bypass_ctrl.sv
`timescale 1ns/1ps
module sim_fwd_bypass_ctrl;
    import fwd_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] dec_cls = '0;
    logic [4:0] dec_dst = '0;
    logic [4:0] dec_rs = '0;
    logic       dec_rs_en = 1'b0;
    logic [4:0] dec_rt = '0;
    logic       dec_rt_en = 1'b0;
    logic [2:0] sel_a, sel_b;
    logic       stall;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fwd_bypass_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .dec_cls(dec_cls), .dec_dst(dec_dst),
        .dec_rs(dec_rs), .dec_rs_en(dec_rs_en),
        .dec_rt(dec_rt), .dec_rt_en(dec_rt_en),
        .sel_a(sel_a), .sel_b(sel_b), .stall(stall)
    );

    task automatic check(string req, string what, int actual, int expected);
        n_checks++;
        if (actual != expected) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
        end
    endtask

    task automatic expect3(string req, int ea, int eb, int es);
        #1;
        check(req, "sel_a", int'(sel_a), ea);
        check(req, "sel_b", int'(sel_b), eb);
        check(req, "stall", int'(stall), es);
    endtask

    // Drive one decode slot (away from the clock edge)
    task automatic put(instr_cls_e c, int dst, int rs, bit rs_en, int rt, bit rt_en);
        dec_cls   = c;
        dec_dst   = 5'(dst);
        dec_rs    = 5'(rs);
        dec_rs_en = rs_en;
        dec_rt    = 5'(rt);
        dec_rt_en = rt_en;
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic flush();
        put(CLS_NOP, 0, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) step();
    endtask

    task automatic t_reset();
        put(CLS_NOP, 0, 3, 1, 3, 1);
        expect3("R1", 0, 0, 0);
    endtask

    task automatic t_ex_alu();
        put(CLS_ALU, 7, 0, 0, 0, 0); step();
        put(CLS_ALUI, 9, 7, 1, 2, 1);
        expect3("R2", 1, 0, 0);
        step();
        put(CLS_NOP, 0, 4, 1, 9, 1);
        expect3("R2", 0, 1, 0);
        flush();
    endtask

    task automatic t_link();
        put(CLS_LINK, 31, 0, 0, 0, 0); step();
        put(CLS_NOP, 0, 1, 1, 31, 1);
        expect3("R3", 0, 2, 0);
        flush();
    endtask

    task automatic t_mem();
        put(CLS_ALUI, 4, 0, 0, 0, 0); step();
        put(CLS_NOP, 0, 0, 0, 0, 0);  step();
        put(CLS_NOP, 0, 4, 1, 0, 0);
        expect3("R5", 3, 0, 0);
        flush();
        put(CLS_LINK, 31, 0, 0, 0, 0); step();
        put(CLS_NOP, 0, 0, 0, 0, 0);   step();
        put(CLS_NOP, 0, 0, 0, 31, 1);
        expect3("R5", 0, 3, 0);
        flush();
    endtask

    task automatic t_wb();
        put(CLS_ALU, 12, 0, 0, 0, 0); step();
        put(CLS_NOP, 0, 0, 0, 0, 0);  step(); step();
        put(CLS_NOP, 0, 12, 1, 12, 1);
        expect3("R6", 5, 5, 0);
        flush();
    endtask

    task automatic t_priority();
        put(CLS_LOAD, 8, 0, 0, 0, 0); step();
        put(CLS_ALU, 8, 0, 0, 0, 0);  step();
        put(CLS_ALUI, 8, 0, 0, 0, 0); step();
        put(CLS_NOP, 0, 8, 1, 8, 1);
        expect3("R7", 1, 1, 0);
        flush();
        put(CLS_ALU, 8, 0, 0, 0, 0);  step();
        put(CLS_LOAD, 8, 0, 0, 0, 0); step();
        put(CLS_NOP, 0, 0, 0, 0, 0);  step();
        put(CLS_NOP, 0, 8, 1, 0, 0);
        expect3("R7", 4, 0, 0);
        flush();
    endtask

    task automatic t_zero();
        put(CLS_ALU, 0, 0, 0, 0, 0); step();
        put(CLS_NOP, 0, 0, 1, 0, 1);
        expect3("R8", 0, 0, 0);
        flush();
        put(CLS_LOAD, 0, 0, 0, 0, 0); step();
        put(CLS_NOP, 0, 0, 1, 0, 1);
        expect3("R8", 0, 0, 0);
        flush();
    endtask

    task automatic t_read_enable();
        put(CLS_ALU, 10, 0, 0, 0, 0); step();
        put(CLS_NOP, 0, 10, 0, 10, 0);
        expect3("R9", 0, 0, 0);
        flush();
        put(CLS_LOAD, 10, 0, 0, 0, 0); step();
        put(CLS_NOP, 0, 10, 0, 10, 0);
        expect3("R9", 0, 0, 0);
        flush();
    endtask

    task automatic t_non_writer();
        put(CLS_STORE, 11, 0, 0, 0, 0);  step();
        put(CLS_BRANCH, 11, 0, 0, 0, 0); step();
        put(CLS_JUMP, 11, 0, 0, 0, 0);   step();
        put(CLS_NOP, 11, 11, 1, 11, 1);
        expect3("R10", 0, 0, 0);
        step();
        put(CLS_NOP, 0, 11, 1, 11, 1);
        expect3("R10", 0, 0, 0);
        flush();
    endtask

    task automatic t_load_use();
        put(CLS_LOAD, 5, 0, 0, 0, 0); step();
        put(CLS_ALU, 6, 5, 1, 6, 1);
        expect3("R4", 0, 0, 1);
        step();                                  // held retry
        expect3("R11", 4, 0, 0);
        step();
        put(CLS_NOP, 0, 6, 1, 5, 1);
        expect3("R11", 1, 5, 0);
        flush();
        put(CLS_LOAD, 13, 0, 0, 0, 0); step();
        put(CLS_NOP, 0, 1, 1, 13, 1);
        expect3("R4", 0, 0, 1);
        step();
        expect3("R4", 0, 4, 0);
        flush();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) @(posedge clk);
        #2 rst_n = 1'b1;
        t_reset();
        t_ex_alu();
        t_link();
        t_mem();
        t_wb();
        t_priority();
        t_zero();
        t_read_enable();
        t_non_writer();
        t_load_use();
        finish_run();
    end

endmodule